// File: doc/BRIEF.md
# Windowed Bus Address Translator

This block rewrites addresses that cross between a local bus and an external bus. Three windows are fixed at build time by parameters. A local memory window and an external memory window each span 64 MB, and a local I/O window spans 256 bytes. Three programmable registers decide where each window lands on the far side.

Each of the two memory-base registers holds four upper-address bytes, one for each 16 MB quarter of its window. The two address bits just above the 16 MB offset pick the quarter. The translated address is that quarter's byte placed above the untouched 24-bit offset. The I/O register relocates the 256-byte I/O window, and the byte offset inside the window is kept.

The block has two independent translation paths:
- An outbound path carries local requests, which are either memory or I/O.
- An inbound path carries external memory requests.

Each path registers its result one cycle after the request, together with a hit flag. A request that falls outside its window comes back with the hit flag low and its address unchanged. The registers are loaded through a simple write port.

Top module: `atx_bridge`

## Requirements
- R1: During and after a synchronous reset, all three base registers are zero, and both paths show valid low, hit low and address zero until a request arrives.
- R2: An outbound memory request (kind flag 0) hits when its address bits 31:26 equal bits 31:26 of the local memory window base. The result, one cycle later, is the quarter's byte in bits 31:24 and the request's bits 23:0 in bits 23:0.
- R3: Address bits 25:24 choose the quarter. Quarter 0 takes register bits 31:24, quarter 1 takes bits 23:16, quarter 2 takes bits 15:8 and quarter 3 takes bits 7:0.
- R4: An inbound request hits when its bits 31:26 equal those of the external memory window base. It is translated in the same way as R2 and R3, using the inbound register.
- R5: An outbound I/O request (kind flag 1) hits when its bits 31:8 equal bits 31:8 of the local I/O window base. Its result is the 24-bit I/O register value in bits 31:8 with the request's bits 7:0 below.
- R6: A request outside its window gives hit low and returns its own address unchanged. This includes a memory address sent with kind flag 1 and an I/O address sent with kind flag 0.
- R7: On a write, select 0 loads the outbound memory register, 1 loads the inbound memory register and 2 loads the I/O register from data bits 23:0, ignoring bits 31:24. Select 3 changes nothing.
- R8: A request presented in the same cycle as a register write is translated with the old value. A request in the next cycle uses the new value.
- R9: Each output valid is its path's request valid delayed by one cycle, and a hit flag is never high while its valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 outbound memory, 1 inbound memory, 2 I/O, 3 none |
| cfg_wdata | input | 32 | Register write data |
| ob_valid | input | 1 | Outbound request valid |
| ob_is_io | input | 1 | Outbound request kind: 0 memory, 1 I/O |
| ob_addr | input | 32 | Outbound local address |
| ob_out_valid | output | 1 | Outbound result valid |
| ob_out_hit | output | 1 | Outbound request fell in its window |
| ob_out_addr | output | 32 | Outbound translated address |
| ib_valid | input | 1 | Inbound request valid |
| ib_addr | input | 32 | Inbound external address |
| ib_out_valid | output | 1 | Inbound result valid |
| ib_out_hit | output | 1 | Inbound request fell in its window |
| ib_out_addr | output | 32 | Inbound translated address |

## Verification
The assertions assume that the request inputs stay known whenever their valid is high. They compare each registered result with the request captured one cycle earlier, so they also assume the kind flag and address are held steady for the cycle in which valid is sampled. The stimulus drives every request field half a period away from the sampling edge and drops valid one cycle later. It keeps the kind flag at 0 for all inbound traffic, because the inbound path has no I/O form, and it writes registers only between requests except in the one case that deliberately overlaps a write with a request.

// File: rtl/atx_pkg.sv
package atx_pkg;
  typedef enum logic [1:0] {
    SEL_OB_MEM = 2'd0,
    SEL_IB_MEM = 2'd1,
    SEL_IO     = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/atx_regs.sv
module atx_regs #(
  parameter int REG_W     = 32,
  parameter int IO_BASE_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [1:0]           sel,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     ob_base,
  output logic [REG_W-1:0]     ib_base,
  output logic [IO_BASE_W-1:0] io_base
);
  import atx_pkg::*;

  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      ob_base <= '0;
      ib_base <= '0;
      io_base <= '0;
    end else if (we) begin
      case (sel_e)
        SEL_OB_MEM: ob_base <= wdata;
        SEL_IB_MEM: ib_base <= wdata;
        SEL_IO:     io_base <= wdata[IO_BASE_W-1:0];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/atx_memwin.sv
module atx_memwin #(
  parameter int          ADDR_W   = 32,
  parameter int          SUB_W    = 24,
  parameter int          SUBS     = 4,
  parameter logic [31:0] WIN_BASE = 32'h0,
  parameter int          BYTE_W   = ADDR_W - SUB_W,
  parameter int          REG_W    = SUBS * BYTE_W
) (
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [REG_W-1:0]  base_reg,
  output logic              hit,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int SEL_W   = $clog2(SUBS);
  localparam int WIN_LSB = SUB_W + SEL_W;

  logic [BYTE_W-1:0] lane [SUBS];
  logic [SEL_W-1:0]  quarter;

  for (genvar i = 0; i < SUBS; i++) begin : g_lane
    assign lane[i] = base_reg[(SUBS-1-i)*BYTE_W +: BYTE_W];
  end

  assign quarter = in_addr[SUB_W +: SEL_W];
  assign hit     = (in_addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);

  always_comb begin
    if (hit) out_addr = {lane[quarter], in_addr[SUB_W-1:0]};
    else     out_addr = in_addr;
  end
endmodule

// File: rtl/atx_iowin.sv
module atx_iowin #(
  parameter int          ADDR_W    = 32,
  parameter int          IO_OFF_W  = 8,
  parameter logic [31:0] WIN_BASE  = 32'h0,
  parameter int          IO_BASE_W = ADDR_W - IO_OFF_W
) (
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [IO_BASE_W-1:0] io_base,
  output logic                 hit,
  output logic [ADDR_W-1:0]    out_addr
);
  assign hit      = (in_addr[ADDR_W-1:IO_OFF_W] == WIN_BASE[ADDR_W-1:IO_OFF_W]);
  assign out_addr = hit ? {io_base, in_addr[IO_OFF_W-1:0]} : in_addr;
endmodule

// File: rtl/atx_outreg.sv
module atx_outreg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_hit,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic [ADDR_W-1:0] out_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= in_valid & in_hit;
      if (in_valid) out_addr <= in_addr;
    end
  end
endmodule

// File: rtl/atx_bridge.sv
module atx_bridge #(
  parameter int          ADDR_W      = 32,
  parameter int          SUB_W       = 24,
  parameter int          SUBS        = 4,
  parameter int          IO_OFF_W    = 8,
  parameter logic [31:0] LOC_MEM_WIN = 32'h4800_0000,
  parameter logic [31:0] EXT_MEM_WIN = 32'h0C00_0000,
  parameter logic [31:0] LOC_IO_WIN  = 32'hFFFF_FC00,
  parameter int          REG_W       = SUBS * (ADDR_W - SUB_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              ob_valid,
  input  logic              ob_is_io,
  input  logic [ADDR_W-1:0] ob_addr,
  output logic              ob_out_valid,
  output logic              ob_out_hit,
  output logic [ADDR_W-1:0] ob_out_addr,
  input  logic              ib_valid,
  input  logic [ADDR_W-1:0] ib_addr,
  output logic              ib_out_valid,
  output logic              ib_out_hit,
  output logic [ADDR_W-1:0] ib_out_addr
);
  localparam int IO_BASE_W = ADDR_W - IO_OFF_W;

  logic [REG_W-1:0]     ob_base_q;
  logic [REG_W-1:0]     ib_base_q;
  logic [IO_BASE_W-1:0] io_base_q;

  logic              ob_mem_hit, ob_io_hit, ib_mem_hit;
  logic [ADDR_W-1:0] ob_mem_addr, ob_io_addr, ib_mem_addr;
  logic              ob_hit_c;
  logic [ADDR_W-1:0] ob_addr_c;

  atx_regs #(.REG_W(REG_W), .IO_BASE_W(IO_BASE_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ob_base(ob_base_q), .ib_base(ib_base_q), .io_base(io_base_q)
  );

  atx_memwin #(.ADDR_W(ADDR_W), .SUB_W(SUB_W), .SUBS(SUBS), .WIN_BASE(LOC_MEM_WIN)) u_ob_mem (
    .in_addr(ob_addr), .base_reg(ob_base_q), .hit(ob_mem_hit), .out_addr(ob_mem_addr)
  );

  atx_iowin #(.ADDR_W(ADDR_W), .IO_OFF_W(IO_OFF_W), .WIN_BASE(LOC_IO_WIN)) u_ob_io (
    .in_addr(ob_addr), .io_base(io_base_q), .hit(ob_io_hit), .out_addr(ob_io_addr)
  );

  atx_memwin #(.ADDR_W(ADDR_W), .SUB_W(SUB_W), .SUBS(SUBS), .WIN_BASE(EXT_MEM_WIN)) u_ib_mem (
    .in_addr(ib_addr), .base_reg(ib_base_q), .hit(ib_mem_hit), .out_addr(ib_mem_addr)
  );

  always_comb begin
    if (ob_is_io) begin
      ob_hit_c  = ob_io_hit;
      ob_addr_c = ob_io_addr;
    end else begin
      ob_hit_c  = ob_mem_hit;
      ob_addr_c = ob_mem_addr;
    end
  end

  atx_outreg #(.ADDR_W(ADDR_W)) u_ob_out (
    .clk(clk), .rst(rst), .in_valid(ob_valid), .in_hit(ob_hit_c), .in_addr(ob_addr_c),
    .out_valid(ob_out_valid), .out_hit(ob_out_hit), .out_addr(ob_out_addr)
  );

  atx_outreg #(.ADDR_W(ADDR_W)) u_ib_out (
    .clk(clk), .rst(rst), .in_valid(ib_valid), .in_hit(ib_mem_hit), .in_addr(ib_mem_addr),
    .out_valid(ib_out_valid), .out_hit(ib_out_hit), .out_addr(ib_out_addr)
  );
endmodule

// File: rtl/atx_bridge_chk.sv
module atx_bridge_chk #(
  parameter int ADDR_W   = 32,
  parameter int SUB_W    = 24,
  parameter int IO_OFF_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ob_valid,
  input logic              ob_is_io,
  input logic [ADDR_W-1:0] ob_addr,
  input logic              ob_out_valid,
  input logic              ob_out_hit,
  input logic [ADDR_W-1:0] ob_out_addr,
  input logic              ib_valid,
  input logic [ADDR_W-1:0] ib_addr,
  input logic              ib_out_valid,
  input logic              ib_out_hit,
  input logic [ADDR_W-1:0] ib_out_addr
);
  AST_OB_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    ob_valid |=> ob_out_valid); // R9
  AST_OB_IDLE_DELAY: assert property (@(posedge clk) disable iff (rst)
    !ob_valid |=> !ob_out_valid); // R9
  AST_IB_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    ib_valid |=> ib_out_valid); // R9
  AST_OB_HIT_GATED: assert property (@(posedge clk) disable iff (rst)
    !ob_out_valid |-> !ob_out_hit); // R9
  AST_IB_HIT_GATED: assert property (@(posedge clk) disable iff (rst)
    !ib_out_valid |-> !ib_out_hit); // R9
  AST_OB_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
    ob_valid |=> (ob_out_hit || ob_out_addr == $past(ob_addr))); // R6
  AST_IB_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
    ib_valid |=> (ib_out_hit || ib_out_addr == $past(ib_addr))); // R6
  AST_OB_MEM_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (ob_valid && !ob_is_io) |=> (!ob_out_hit || ob_out_addr[SUB_W-1:0] == $past(ob_addr[SUB_W-1:0]))); // R2
  AST_IB_MEM_OFFSET: assert property (@(posedge clk) disable iff (rst)
    ib_valid |=> (!ib_out_hit || ib_out_addr[SUB_W-1:0] == $past(ib_addr[SUB_W-1:0]))); // R4
  AST_OB_IO_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (ob_valid && ob_is_io) |=> (!ob_out_hit || ob_out_addr[IO_OFF_W-1:0] == $past(ob_addr[IO_OFF_W-1:0]))); // R5
endmodule

bind atx_bridge atx_bridge_chk #(.ADDR_W(ADDR_W), .SUB_W(SUB_W), .IO_OFF_W(IO_OFF_W)) u_chk (
  .clk(clk), .rst(rst),
  .ob_valid(ob_valid), .ob_is_io(ob_is_io), .ob_addr(ob_addr),
  .ob_out_valid(ob_out_valid), .ob_out_hit(ob_out_hit), .ob_out_addr(ob_out_addr),
  .ib_valid(ib_valid), .ib_addr(ib_addr),
  .ib_out_valid(ib_out_valid), .ib_out_hit(ib_out_hit), .ib_out_addr(ib_out_addr)
);

// File: tb/atx_bridge_test.sv
`timescale 1ns/1ps
module atx_bridge_test;
  localparam logic [31:0] LMW = 32'h4800_0000;
  localparam logic [31:0] EMW = 32'h0C00_0000;
  localparam logic [31:0] LIW = 32'hFFFF_FC00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        ob_valid = 1'b0, ob_is_io = 1'b0;
  logic [31:0] ob_addr = '0;
  logic        ib_valid = 1'b0;
  logic [31:0] ib_addr = '0;
  logic        ob_out_valid, ob_out_hit, ib_out_valid, ib_out_hit;
  logic [31:0] ob_out_addr, ib_out_addr;

  int total = 0;
  int bad = 0;
  logic [31:0] m_ob = '0, m_ib = '0;
  logic [23:0] m_io = '0;

  always #4 clk = ~clk;

  atx_bridge #(.LOC_MEM_WIN(LMW), .EXT_MEM_WIN(EMW), .LOC_IO_WIN(LIW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ob_valid(ob_valid), .ob_is_io(ob_is_io), .ob_addr(ob_addr),
    .ob_out_valid(ob_out_valid), .ob_out_hit(ob_out_hit), .ob_out_addr(ob_out_addr),
    .ib_valid(ib_valid), .ib_addr(ib_addr),
    .ib_out_valid(ib_out_valid), .ib_out_hit(ib_out_hit), .ib_out_addr(ib_out_addr)
  );

  function automatic logic [32:0] exp_mem(logic [31:0] r, logic [31:0] w, logic [31:0] a);
    int lane;
    if (a[31:26] != w[31:26]) return {1'b0, a};
    lane = 3 - int'(a[25:24]);
    return {1'b1, r[lane*8 +: 8], a[23:0]};
  endfunction

  function automatic logic [32:0] exp_io(logic [23:0] r, logic [31:0] a);
    if (a[31:8] != LIW[31:8]) return {1'b0, a};
    return {1'b1, r, a[7:0]};
  endfunction

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    case (s)
      2'd0: m_ob = d;
      2'd1: m_ib = d;
      2'd2: m_io = d[23:0];
      default: ;
    endcase
  endtask

  task automatic run_ob(string req, logic io, logic [31:0] a);
    ob_valid = 1'b1; ob_is_io = io; ob_addr = a;
    @(posedge clk); @(negedge clk);
    ob_valid = 1'b0;
    check(req, {ob_out_valid, 32'h0}, {1'b1, 32'h0});
    check(req, {ob_out_hit, ob_out_addr}, io ? exp_io(m_io, a) : exp_mem(m_ob, LMW, a));
  endtask

  task automatic run_ib(string req, logic [31:0] a);
    ib_valid = 1'b1; ib_addr = a;
    @(posedge clk); @(negedge clk);
    ib_valid = 1'b0;
    check(req, {ib_out_valid, 32'h0}, {1'b1, 32'h0});
    check(req, {ib_out_hit, ib_out_addr}, exp_mem(m_ib, EMW, a));
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] cfgs [3];
    logic [23:0] offs [3];
    cfgs[0] = 32'h2021_2223; cfgs[1] = 32'hA107_FF3C; cfgs[2] = 32'h0000_0000;
    offs[0] = 24'h000000; offs[1] = 24'h123456; offs[2] = 24'hFFFFFF;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", {ob_out_valid, ob_out_hit, ib_out_valid, ib_out_hit, 29'h0}, 33'h0);
    check("R1", {1'b0, ob_out_addr}, 33'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {ob_out_valid, ib_out_valid, 31'h0}, 33'h0);
    run_ob("R1", 1'b0, LMW | 32'h0100_0abc);   // registers still zero
    run_ob("R1", 1'b1, LIW | 32'h0000_0077);

    // R2 R3 R4: sweep configurations, quarters and offsets
    for (int c = 0; c < 3; c++) begin
      wr(2'd0, cfgs[c]);
      wr(2'd1, ~cfgs[c]);
      for (int q = 0; q < 4; q++) begin
        for (int o = 0; o < 3; o++) begin
          run_ob("R2_R3", 1'b0, LMW | (32'(q) << 24) | 32'(offs[o]));
          run_ib("R4_R3", EMW | (32'(q) << 24) | 32'(offs[o]));
        end
      end
    end

    // R6: misses on each path
    run_ob("R6", 1'b0, 32'h4400_0000);
    run_ob("R6", 1'b0, 32'h4C12_3456);
    run_ob("R6", 1'b0, 32'h0000_0010);
    run_ib("R6", 32'h0800_1111);
    run_ib("R6", 32'h1000_0000);
    run_ob("R6", 1'b1, LMW | 32'h0000_0042);   // memory address, I/O kind
    run_ob("R6", 1'b0, LIW | 32'h0000_0042);   // I/O address, memory kind

    // R5 R7: I/O register takes low 24 bits only
    wr(2'd2, 32'hFFAB_CDEF);
    check("R7", {9'h0, m_io}, {9'h0, 24'hABCDEF});
    for (int o = 0; o < 256; o += 17) run_ob("R5", 1'b1, LIW | 32'(o));
    run_ob("R5", 1'b1, LIW | 32'h0000_00FF);
    run_ob("R6", 1'b1, 32'hFFFF_FB00);
    run_ob("R6", 1'b1, 32'hFFFF_FD00);

    // R7: select 3 changes nothing
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h5555_5555;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    for (int q = 0; q < 4; q++) begin
      run_ob("R7", 1'b0, LMW | (32'(q) << 24) | 32'h0000_0abc);
      run_ib("R7", EMW | (32'(q) << 24) | 32'h0000_0abc);
    end
    run_ob("R7", 1'b1, LIW | 32'h0000_0011);

    // R8: write and request in the same cycle
    begin
      logic [32:0] old_e;
      old_e = exp_mem(m_ob, LMW, LMW | 32'h0001_2345);
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h9988_7766;
      ob_valid = 1'b1; ob_is_io = 1'b0; ob_addr = LMW | 32'h0001_2345;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0; ob_valid = 1'b0;
      m_ob = 32'h9988_7766;
      check("R8", {ob_out_hit, ob_out_addr}, old_e);
      run_ob("R8", 1'b0, LMW | 32'h0001_2345);
    end

    // R9: valid drops one cycle after request drops
    @(negedge clk);
    check("R9", {ob_out_valid, ob_out_hit, ib_out_valid, ib_out_hit, 29'h0}, 33'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule